// File: doc/BRIEF.md
# Single-Wire Bus Read-Slot Master

This block reads bits from a slave on an open-drain, single-wire bus that has a pull-up resistor. A request asks for one bit or one byte. For each bit the block opens a read slot: it pulls the line low for a short pulse and then lets it go. The slave either holds the line low, which returns a 0, or leaves it to the pull-up, which returns a 1. The block samples the line late in the slave's short valid-data window. It then waits out the rest of the slot and a recovery gap before the next slot starts.

The block drives the bus only through an enable for a pull-low driver. It never drives the line high. The line level comes back through a two-flop synchronizer. All timing is counted in microseconds from a tick, and the tick is divided down from the system clock. The pulse length, the sample point, the slot length and the recovery gap are parameters. The low pulse plus the bus rise time plus the sample delay must stay below 15 µs after the falling edge. The defaults are a 2 µs pulse and a sample at 13 µs. When the request is finished, a one-cycle done strobe marks the result.

Top module: `ow_read_master`

## Requirements
- R1: After reset, `pull_low_o`, `busy_o` and `done_o` are 0 and `data_o` is 0.
- R2: A request seen while idle makes `busy_o` and `pull_low_o` high from the next cycle on. `pull_low_o` is only ever high while `busy_o` is high.
- R3: Each slot's low pulse lasts exactly LOW_US microseconds, which is LOW_US*CLK_PER_US clock cycles. After the pulse the line is released, and it is still released at the sample point.
- R4: The line is sampled SAMPLE_US microseconds after the slot's falling edge. A high level gives a 1 and a low level gives a 0.
- R5: Consecutive slots in one request start SLOT_US+RECOVER_US microseconds apart, which is 61 µs by default. The line stays released for at least RECOVER_US microseconds before each new slot.
- R6: A byte request (`byte_mode_i`=1) runs exactly eight slots. The first bit read lands in `data_o[0]` and the last bit read lands in `data_o[7]`.
- R7: A bit request (`byte_mode_i`=0) runs exactly one slot. It returns the bit in `data_o[0]`, with `data_o[7:1]`=0.
- R8: `done_o` is high for exactly one cycle. `busy_o` falls in that same cycle. `data_o` holds its value until the next done.
- R9: A request that arrives while busy is ignored. The running request keeps its mode and slot count, and no extra slot follows it.
- R10: The result reflects the line level at the sample point. If a slave releases the line before SAMPLE_US, the block reads a 1. If it holds the line past SAMPLE_US, the block reads a 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 1 | Request to start a read |
| byte_mode_i | input | 1 | 1 reads a byte (8 slots), 0 reads one bit |
| line_i | input | 1 | Raw bus level (asynchronous) |
| pull_low_o | output | 1 | Enable for the pull-low driver |
| busy_o | output | 1 | A read is in progress |
| done_o | output | 1 | One-cycle strobe when the result is ready |
| data_o | output | 8 | Result, least significant bit read first |

## Verification
The hardest case to reach is a slave whose low hold ends close to the sample point. In that case the result depends on where inside the window the sample falls, and not on the bit value alone. The bench's slave model has a programmable hold time. It runs all-zero bytes with holds that end just before and just after 13 µs, and it expects all ones and all zeros respectively. To exercise R9, a second request is pulsed in the middle of a byte, and the bench counts the slots that follow it.

// File: rtl/ow_read_master.sv
module ow_read_master #(
  parameter int CLK_PER_US = 125,
  parameter int LOW_US     = 2,
  parameter int SAMPLE_US  = 13,
  parameter int SLOT_US    = 60,
  parameter int RECOVER_US = 1,
  parameter int BITS       = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_i,
  input  logic            byte_mode_i,
  input  logic            line_i,
  output logic            pull_low_o,
  output logic            busy_o,
  output logic            done_o,
  output logic [BITS-1:0] data_o
);
  localparam int TOTAL_US = SLOT_US + RECOVER_US;
  localparam int DIV_W    = $clog2(CLK_PER_US + 1);
  localparam int CNT_W    = $clog2(TOTAL_US + 1);
  localparam int IDX_W    = $clog2(BITS + 1);
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(CLK_PER_US - 1);
  localparam logic [CNT_W-1:0] LOW_CNT  = CNT_W'(LOW_US);
  localparam logic [CNT_W-1:0] SMP_CNT  = CNT_W'(SAMPLE_US - 1);
  localparam logic [CNT_W-1:0] END_CNT  = CNT_W'(TOTAL_US - 1);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(BITS - 1);

  logic [1:0]      sync;
  logic [DIV_W-1:0] div;
  logic [CNT_W-1:0] us_cnt;
  logic [IDX_W-1:0] bit_idx;
  logic            mode_q;
  logic [BITS-1:0] shreg;

  wire tick      = busy_o && (div == DIV_LAST);
  wire sample_en = tick && (us_cnt == SMP_CNT);
  wire slot_end  = tick && (us_cnt == END_CNT);
  wire last_slot = !mode_q || (bit_idx == IDX_LAST);

  assign pull_low_o = busy_o && (us_cnt < LOW_CNT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync    <= 2'b11;
      div     <= '0;
      us_cnt  <= '0;
      bit_idx <= '0;
      mode_q  <= 1'b0;
      busy_o  <= 1'b0;
      done_o  <= 1'b0;
      shreg   <= '0;
      data_o  <= '0;
    end else begin
      sync   <= {sync[0], line_i};
      done_o <= 1'b0;
      if (!busy_o) begin
        if (req_i) begin
          busy_o  <= 1'b1;
          mode_q  <= byte_mode_i;
          div     <= '0;
          us_cnt  <= '0;
          bit_idx <= '0;
        end
      end else begin
        div <= tick ? '0 : div + 1'b1;
        if (tick) us_cnt <= slot_end ? '0 : us_cnt + 1'b1;
        if (sample_en) shreg <= {sync[1], shreg[BITS-1:1]};
        if (slot_end) begin
          if (last_slot) begin
            busy_o <= 1'b0;
            done_o <= 1'b1;
            data_o <= mode_q ? shreg : {{(BITS-1){1'b0}}, shreg[BITS-1]};
          end else begin
            bit_idx <= bit_idx + 1'b1;
          end
        end
      end
    end
  end

  AST_PULL_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    pull_low_o |-> busy_o); // R2
  AST_RELEASED_AT_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
    sample_en |-> !pull_low_o); // R3
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R8
  AST_BUSY_ENDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> done_o); // R8
  AST_MODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o)) |-> $stable(mode_q)); // R9
  AST_RELEASED_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
    slot_end |=> !$past(pull_low_o)); // R5
endmodule

// File: tb/sim_ow_read_master.sv
`timescale 1ns/1ps
module sim_ow_read_master;
  localparam int CPU = 8;
  localparam int SLOT_CYC = 61 * CPU;
  localparam int LOW_CYC = 2 * CPU;

  logic clk = 0, rst_n = 0, req = 0, bmode = 0;
  logic pull_low, busy, done;
  logic [7:0] data;
  logic slave_low = 0;
  logic [7:0] pattern = 0;
  int hold_us = 15;
  int slave_idx = 0;
  int vectors = 0, errors = 0;
  int cyc = 0, slots = 0, last_rise = 0, rise_at = 0;
  logic prev_pull = 0;
  logic [7:0] exp_data_q[$];
  int exp_slots_q[$];

  wire line = !(pull_low || slave_low);
  always #4 clk = ~clk;

  ow_read_master #(.CLK_PER_US(CPU)) u0 (
    .clk(clk), .rst_n(rst_n), .req_i(req), .byte_mode_i(bmode), .line_i(line),
    .pull_low_o(pull_low), .busy_o(busy), .done_o(done), .data_o(data));

  task automatic chk(input bit ok, input string r, input int act, input int exp);
    vectors++;
    if (!ok) begin errors++; $display("FAIL %s actual=%0d expected=%0d", r, act, exp); end
  endtask

  initial forever begin
    @(posedge pull_low);
    if (!pattern[slave_idx % 8]) begin
      slave_low = 1;
      #(hold_us * CPU * 8);
      slave_low = 0;
    end
    slave_idx++;
  end

  always @(negedge clk) begin
    cyc++;
    if (pull_low && !prev_pull) begin
      if (slots > 0) chk(cyc - last_rise == SLOT_CYC, "R5 slot period", cyc - last_rise, SLOT_CYC);
      last_rise = cyc; rise_at = cyc; slots++;
    end
    if (!pull_low && prev_pull)
      chk(cyc - rise_at == LOW_CYC, "R3 low pulse", cyc - rise_at, LOW_CYC);
    prev_pull = pull_low;
    if (done) begin
      chk(!busy, "R8 busy falls with done", busy, 0);
      if (exp_data_q.size() == 0) chk(0, "R9 unexpected done", 1, 0);
      else begin
        automatic logic [7:0] e = exp_data_q.pop_front();
        automatic int es = exp_slots_q.pop_front();
        chk(data == e, "R4/R6/R7/R10 data", data, e);
        chk(slots == es, "R6/R7/R9 slot count", slots, es);
      end
      slots = 0;
    end
  end

  task automatic run(input logic m, input logic [7:0] pat, input int hold, input logic [7:0] e, input bit extra_req);
    pattern = pat; hold_us = hold; slave_idx = 0;
    @(negedge clk);
    exp_data_q.push_back(e); exp_slots_q.push_back(m ? 8 : 1);
    req = 1; bmode = m;
    @(negedge clk);
    req = 0;
    chk(busy && pull_low, "R2 accept", {busy, pull_low}, 3);
    if (extra_req) begin
      repeat (3 * SLOT_CYC) @(negedge clk);
      req = 1; bmode = 0; @(negedge clk); req = 0;
    end
    @(posedge done); @(negedge clk); @(negedge clk);
    chk(!done, "R8 done one cycle", done, 0);
    chk(data == e, "R8 data held", data, e);
  endtask

  initial begin
    fork
      begin
        repeat (150000) @(posedge clk);
        chk(0, "watchdog", 0, 1);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
      end
    join_none
    repeat (4) @(negedge clk);
    chk(!pull_low && !busy && !done && data == 0, "R1 reset", {pull_low, busy, done}, 0);
    rst_n = 1;
    repeat (3) @(negedge clk);
    chk(!pull_low && !busy, "R1 idle", {pull_low, busy}, 0);
    run(1, 8'hA5, 15, 8'hA5, 0);
    run(1, 8'h3C, 15, 8'h3C, 0);
    run(0, 8'h01, 15, 8'h01, 0);
    run(0, 8'h00, 15, 8'h00, 0);
    run(1, 8'h00, 12, 8'hFF, 0);
    run(1, 8'h00, 14, 8'h00, 0);
    run(1, 8'h96, 15, 8'h96, 1);
    slots = 0;
    repeat (2 * SLOT_CYC) @(negedge clk);
    chk(slots == 0 && !busy, "R9 no extra slot", slots, 0);
    chk(exp_data_q.size() == 0, "R6 all results seen", exp_data_q.size(), 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule